// File: doc/BRIEF.md
# Cascadable Shift-and-Store Register

This block takes in a bit stream one bit per rising edge of its shift clock and moves it through an eight-stage shift chain. A second eight-bit store sits behind the chain. The strobe opens the store, and while it is open the store follows the chain. When the strobe falls, the store keeps the last word it saw. The stored word leaves on a parallel bus. An enable input either drives this bus or switches it to high impedance, and it never touches any stored bit.

The last stage feeds two serial outputs so that several blocks can be chained. The first serial output changes on the rising edge. The second carries the same bit but changes only on the following falling edge. This gives a downstream block half a period of hold margin when the clock edges are slow. An active-low asynchronous reset clears all state.

Top module: `shift_store_reg`

## Requirements
- R1: While `rstN` is low, the shift chain, the store and both serial outputs are zero.
- R2: On each rising edge of `clk`, stage 0 takes `serialIn` and every stage i>0 takes the old value of stage i-1. Bit i of `parOut` shows stage i, so bit 0 holds the newest bit.
- R3: `casRise` equals stage 7 and changes only on a rising edge of `clk`.
- R4: `casFall` takes the value of stage 7 on each falling edge of `clk`. Between a rising edge and the next falling edge it keeps the value from before that rising edge.
- R5: While `strobe` is high, the store is transparent and equals the shift chain.
- R6: While `strobe` is low, the store keeps the word it held when `strobe` fell, however much the chain shifts.
- R7: With `outEn` high, `parOut` drives the store. With `outEn` low, every bit of `parOut` is high impedance.
- R8: Changing `outEn` alters neither the shift chain nor the store.
- R9: Two instances with the second's `serialIn` tied to the first's `casFall` act as one 16-stage chain. After 16 shifts of word P (MSB first), the concatenation {second `parOut`, first `parOut`} equals P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rstN | input | 1 | Active-low asynchronous clear |
| serialIn | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | High: store follows the shift chain |
| outEn | input | 1 | High: drive parOut; low: high impedance |
| parOut | output | WIDTH | Three-state parallel view of the store |
| casRise | output | 1 | Last stage, rising-edge timed |
| casFall | output | 1 | Last stage, retimed on the falling edge |

## Verification
The assertions assume that `strobe`, `outEn` and `serialIn` change only while `clk` is low and never close to either edge. Under that assumption the transparent store is settled whenever it is sampled, and a strobe that is low across a whole cycle truly means the store was closed. The bench drives every input three nanoseconds after a falling edge. It never moves an input near a rising edge, and it releases reset in the same low phase.

// File: rtl/shreg_pkg.sv
`timescale 1ns/1ps
package shreg_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic storeOpen;  // store transparent
    logic driveOut;   // parallel bus driven
  } shreg_ctrl_t;
endpackage

// File: rtl/shreg_ctrl.sv
`timescale 1ns/1ps
module shreg_ctrl
  import shreg_pkg::*;
(
  input  logic        strobe,
  input  logic        outEn,
  output shreg_ctrl_t ctrl
);
  always_comb begin
    ctrl           = '0;
    ctrl.storeOpen = strobe;
    ctrl.driveOut  = outEn;
  end
endmodule

// File: rtl/shreg_datapath.sv
`timescale 1ns/1ps
module shreg_datapath
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serialIn,
  input  shreg_ctrl_t      ctrl,
  output logic [WIDTH-1:0] stageQ,
  output logic [WIDTH-1:0] storeQ,
  output logic             tapRise,
  output logic             tapFall
);
  localparam int LAST = WIDTH - 1;

  // Shift chain: stage 0 takes the serial input
  for (genvar g = 0; g < WIDTH; g++) begin : gStage
    if (g == 0) begin : gHead
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= 1'b0;
        else       stageQ[g] <= serialIn;
      end
    end else begin : gBody
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= 1'b0;
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  // Level-sensitive store
  always_latch begin
    if (!rstN)               storeQ <= '0;
    else if (ctrl.storeOpen) storeQ <= stageQ;
  end

  // Falling-edge retimed copy of the last stage
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) tapFall <= 1'b0;
    else       tapFall <= stageQ[LAST];
  end

  assign tapRise = stageQ[LAST];
endmodule

// File: rtl/shift_store_reg.sv
`timescale 1ns/1ps
module shift_store_reg
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serialIn,
  input  logic             strobe,
  input  logic             outEn,
  output logic [WIDTH-1:0] parOut,
  output logic             casRise,
  output logic             casFall
);
  shreg_ctrl_t      ctrl;
  logic [WIDTH-1:0] shiftBus;
  logic [WIDTH-1:0] storeBus;

  shreg_ctrl uCtrl (
    .strobe (strobe),
    .outEn  (outEn),
    .ctrl   (ctrl)
  );

  shreg_datapath #(.WIDTH(WIDTH)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .serialIn (serialIn),
    .ctrl     (ctrl),
    .stageQ   (shiftBus),
    .storeQ   (storeBus),
    .tapRise  (casRise),
    .tapFall  (casFall)
  );

  // Three-state wrapper
  assign parOut = ctrl.driveOut ? storeBus : {WIDTH{1'bz}};
endmodule

// File: rtl/shift_store_reg_chk.sv
`timescale 1ns/1ps
module shift_store_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             serialIn,
  input logic             strobe,
  input logic             outEn,
  input logic [WIDTH-1:0] parOut,
  input logic             casRise,
  input logic             casFall,
  input logic [WIDTH-1:0] shiftBus,
  input logic [WIDTH-1:0] storeBus
);
  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (shiftBus[0] == $past(serialIn)) &&
                    (shiftBus[WIDTH-1:1] == $past(shiftBus[WIDTH-2:0])));

  assert_rise_tap_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> casRise == $past(shiftBus[WIDTH-2]));

  assert_fall_copy_R4: assert property (@(posedge clk) disable iff (!rstN)
    casFall == casRise);

  assert_store_follow_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe |-> storeBus == shiftBus);

  assert_store_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!strobe) && !strobe) |-> $stable(storeBus));

  assert_bus_drive_R7: assert property (@(posedge clk) disable iff (!rstN)
    outEn |-> parOut == storeBus);
endmodule

bind shift_store_reg shift_store_reg_chk #(.WIDTH(WIDTH)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .serialIn (serialIn),
  .strobe   (strobe),
  .outEn    (outEn),
  .parOut   (parOut),
  .casRise  (casRise),
  .casFall  (casFall),
  .shiftBus (shiftBus),
  .storeBus (storeBus)
);

// File: tb/sim_shift_store_reg.sv
`timescale 1ns/1ps
module sim_shift_store_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rstN, din, stb, oe;
  wire [W-1:0] par0, par1;
  wire rise0, fall0, rise1, fall1;

  shift_store_reg #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .serialIn(din), .strobe(stb), .outEn(oe),
    .parOut(par0), .casRise(rise0), .casFall(fall0));

  shift_store_reg #(.WIDTH(W)) u1 (
    .clk(clk), .rstN(rstN), .serialIn(fall0), .strobe(stb), .outEn(oe),
    .parOut(par1), .casRise(rise1), .casFall(fall1));

  bit model[$];          // index 0 = newest bit of the 16-stage chain
  bit [W-1:0] held0, held1;
  bit prevTap0, prevTap1;
  int tests = 0, fails = 0;
  bit done = 0;

  function automatic bit [W-1:0] slice(int base);
    bit [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = model[base+i];
    return v;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // Drive in low phase, check after rising and after falling edges
  task automatic cycle(bit d, bit s, bit o);
    din = d; stb = s; oe = o;
    prevTap0 = model[7];
    prevTap1 = model[15];
    @(posedge clk);
    model.push_front(d);
    void'(model.pop_back());
    if (s) begin held0 = slice(0); held1 = slice(8); end
    #3;
    if (o) begin
      chk(s ? "R2 R5 par0" : "R6 par0", {8'h0, par0}, {8'h0, held0});
      chk(s ? "R9 R5 par1" : "R6 par1", {8'h0, par1}, {8'h0, held1});
    end else begin
      chk("R7 par0 hiz", {8'h0, par0}, {8'h0, {W{1'bz}}});
      chk("R7 par1 hiz", {8'h0, par1}, {8'h0, {W{1'bz}}});
    end
    chk("R3 rise0", {15'h0, rise0}, {15'h0, model[7]});
    chk("R4 fall0 before negedge", {15'h0, fall0}, {15'h0, prevTap0});
    chk("R9 rise1", {15'h0, rise1}, {15'h0, model[15]});
    @(negedge clk);
    #3;
    chk("R4 fall0 after negedge", {15'h0, fall0}, {15'h0, model[7]});
    chk("R9 fall1", {15'h0, fall1}, {15'h0, model[15]});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R9 run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] pat;
    logic [7:0]  lfsr;
    rstN = 1'b0; din = 1'b1; stb = 1'b1; oe = 1'b1;
    for (int i = 0; i < 16; i++) model.push_back(1'b0);
    held0 = '0; held1 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #3;
    // R1: reset state while din is high and clock running
    chk("R1 par0", {8'h0, par0}, 16'h0);
    chk("R1 par1", {8'h0, par1}, 16'h0);
    chk("R1 taps", {12'h0, rise0, fall0, rise1, fall1}, 16'h0);
    rstN = 1'b1;

    // Stream a 16-bit word MSB first, store open, bus driven
    pat = 16'hA5C3;
    for (int i = 15; i >= 0; i--) cycle(pat[i], 1'b1, 1'b1);
    chk("R9 chained word", {par1, par0}, pat);

    // Store closed: keep shifting, outputs hold
    for (int i = 0; i < 6; i++) cycle(i[0] ^ i[1], 1'b0, 1'b1);
    chk("R6 held word", {par1, par0}, pat);

    // Toggle enable with store closed
    for (int i = 0; i < 6; i++) cycle(i[1], 1'b0, i[0]);
    cycle(1'b1, 1'b0, 1'b1);
    chk("R8 store unchanged by outEn", {par1, par0}, pat);

    // Reopen store: shift chain unaffected by enable toggling
    cycle(1'b0, 1'b1, 1'b1);
    chk("R8 chain intact after outEn", {par1, par0}, {slice(8), slice(0)});

    // Pseudo-random mix of data, strobe and enable
    lfsr = 8'hE1;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cycle(lfsr[0], lfsr[2] | lfsr[5], lfsr[3] | lfsr[6]);
    end

    // Second chained word
    pat = 16'h3C96;
    for (int i = 15; i >= 0; i--) cycle(pat[i], 1'b1, 1'b1);
    chk("R9 second chained word", {par1, par0}, pat);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule